// File: doc/BRIEF.md
# Oscillator Divider and Rate Selector

This block is the countdown chain that sits behind a 32.768 kHz timekeeping oscillator. A clock enable, `osc_tick`, marks each half-period of the oscillator, 65,536 times a second. A phase flop built from it forms the 32 kHz square wave. A 15-stage binary counter advances once per full oscillator period, so stage k toggles at 32768 / 2^(k+1) Hz and the last stage runs at 1 Hz.

A three-bit control field picks one of three states. In run, the oscillator and the chain both advance. In hold, the oscillator runs and the chain is kept cleared. In off, nothing moves. A four-bit rate code selects one counter stage. That selected stage feeds the square-wave pin and a one-cycle periodic event pulse. A force bit puts the raw 32 kHz phase on the pin instead. When the main supply is reported low, the pin is driven only if the force bit, the auxiliary-battery enable and the auxiliary-valid flag are all set. A separate one-cycle tick marks each rising edge of the 1 Hz stage.

Top module: `osc_rate_div`

## Requirements
- R1: With `div_ctl[2:1]` = 01 (run), the chain advances once on every second asserted `osc_tick`. With `osc_tick` low, it does not advance. After reset in run with `osc_tick` held high, the stage for rate code c first rises on clock edge 2^(k+1), where k is the stage index from R4.
- R2: With `div_ctl[2:1]` = 11 (hold), the chain stays cleared: no `per_pulse`, no `sec_tick`, and the selected rate output is 0. The 32 kHz phase keeps toggling on each `osc_tick`.
- R3: With `div_ctl[1]` = 0 (off), neither the chain nor the 32 kHz phase changes, and no pulses appear.
- R4: Rate code 0 selects nothing. Code 1 selects stage 6 (256 Hz), code 2 selects stage 7 (128 Hz) and code 3 selects stage 1 (8192 Hz). Codes 4 to 15 select stage code−2, which gives 4096 Hz halving down to 2 Hz.
- R5: `per_pulse` is high for exactly one clock after each rising edge of the selected stage. It is registered in the same edge that updates the chain.
- R6: When `force_32k` = 0 and the main supply is good, `sqw` equals the selected stage if `sqw_en` = 1 and is 0 otherwise. `per_pulse` does not depend on `sqw_en`.
- R7: When `force_32k` = 1 and the main supply is good, `sqw` carries the 32 kHz phase, whatever the values of `rate_sel` and `sqw_en`.
- R8: When `main_low` = 1, `sqw` carries the 32 kHz phase if `force_32k`, `aux_en` and `aux_ok` are all 1, and is 0 otherwise.
- R9: `sec_tick` pulses for one clock on each rising edge of stage 14. After reset in run with `osc_tick` held high, this is first on edge 32768.
- R10: While `rst_n` is low, the chain and the phase are cleared and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Enable, one per oscillator half-period |
| div_ctl | input | 3 | Chain control: 01x run, 11x hold, else off |
| rate_sel | input | 4 | Rate code selecting the chain stage |
| sqw_en | input | 1 | Gates the selected rate onto `sqw` |
| force_32k | input | 1 | Puts the 32 kHz phase on `sqw` |
| aux_en | input | 1 | Allows 32 kHz output from the auxiliary battery |
| aux_ok | input | 1 | Auxiliary supply is valid |
| main_low | input | 1 | Main supply is below its trip point |
| sqw | output | 1 | Square-wave output |
| per_pulse | output | 1 | One-cycle pulse per rising edge of the selected stage |
| sec_tick | output | 1 | One-cycle pulse per rising edge of the 1 Hz stage |

## Verification
The bench walks all sixteen rate codes and measures the latency of the first periodic pulse from reset. A wrong entry in the code-to-stage mapping, or a chain that counts every tick instead of every second tick, shows up as an exact cycle-count mismatch. Hold and off are checked separately: a design that confuses them either keeps the 32 kHz phase running while off or stops it while held. The bench also checks the supply-low gating with each auxiliary qualifier removed, since a design that ignores one qualifier would leak the 32 kHz wave onto the pin. Finally, it confirms that each pulse lasts a single cycle and that `sqw_en` masks the pin but not the pulse.

// File: rtl/osc_rate_div.sv
module osc_rate_div #(
  parameter int CHAIN_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [2:0] div_ctl,
  input  logic [3:0] rate_sel,
  input  logic       sqw_en,
  input  logic       force_32k,
  input  logic       aux_en,
  input  logic       aux_ok,
  input  logic       main_low,
  output logic       sqw,
  output logic       per_pulse,
  output logic       sec_tick
);
  localparam int TAP_W = $clog2(CHAIN_W);

  logic               osc_on, run, hold, adv, osc_ph, sel_on, tap_now, tap_nxt;
  logic [CHAIN_W-1:0] chain, chain_inc;
  logic [TAP_W-1:0]   tap;

  assign osc_on    = div_ctl[1];
  assign run       = (div_ctl[2:1] == 2'b01);
  assign hold      = (div_ctl[2:1] == 2'b11);
  assign adv       = osc_tick & run & osc_ph;
  assign chain_inc = chain + CHAIN_W'(1);
  assign sel_on    = (rate_sel != 4'd0);

  always_comb begin
    case (rate_sel)
      4'd1:    tap = TAP_W'(6);
      4'd2:    tap = TAP_W'(7);
      4'd3:    tap = TAP_W'(1);
      default: tap = TAP_W'(rate_sel - 4'd2);
    endcase
  end

  assign tap_now = sel_on & chain[tap];
  assign tap_nxt = sel_on & chain_inc[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_ph    <= 1'b0;
      chain     <= '0;
      per_pulse <= 1'b0;
      sec_tick  <= 1'b0;
    end else begin
      if (osc_tick && osc_on) osc_ph <= ~osc_ph;
      if (hold)     chain <= '0;
      else if (adv) chain <= chain_inc;
      per_pulse <= adv & tap_nxt & ~tap_now;
      sec_tick  <= adv & chain_inc[CHAIN_W-1] & ~chain[CHAIN_W-1];
    end
  end

  always_comb begin
    if (main_low)       sqw = force_32k & aux_en & aux_ok & osc_ph;
    else if (force_32k) sqw = osc_ph;
    else                sqw = sqw_en & tap_now;
  end
endmodule

module osc_rate_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_tick,
  input logic [2:0] div_ctl,
  input logic [3:0] rate_sel,
  input logic       sqw_en,
  input logic       force_32k,
  input logic       aux_en,
  input logic       aux_ok,
  input logic       main_low,
  input logic       sqw,
  input logic       per_pulse,
  input logic       sec_tick
);
  a_r1_no_tick_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> (!per_pulse && !sec_tick));
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctl[2:1] == 2'b11) |=> (!per_pulse && !sec_tick));
  a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !div_ctl[1] |=> (!per_pulse && !sec_tick));
  a_r4_code0_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !per_pulse);
  a_r5_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> !per_pulse);
  a_r6_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sqw_en && !force_32k) |-> !sqw);
  a_r8_supply_low: assert property (@(posedge clk) disable iff (!rst_n)
    (main_low && !(force_32k && aux_en && aux_ok)) |-> !sqw);
  a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
endmodule

bind osc_rate_div osc_rate_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .div_ctl(div_ctl),
  .rate_sel(rate_sel), .sqw_en(sqw_en), .force_32k(force_32k),
  .aux_en(aux_en), .aux_ok(aux_ok), .main_low(main_low),
  .sqw(sqw), .per_pulse(per_pulse), .sec_tick(sec_tick)
);

// File: tb/osc_rate_div_bench.sv
`timescale 1ns/1ps
module osc_rate_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [2:0] div_ctl = 3'b000;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b0, force_32k = 1'b0, aux_en = 1'b0, aux_ok = 1'b0, main_low = 1'b0;
  logic       sqw, per_pulse, sec_tick;
  int         nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  osc_rate_div u_osc_rate_div (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .sqw_en(sqw_en), .force_32k(force_32k),
    .aux_en(aux_en), .aux_ok(aux_ok), .main_low(main_low),
    .sqw(sqw), .per_pulse(per_pulse), .sec_tick(sec_tick)
  );

  // {rate code, first-pulse edge count from reset; 0 = never}
  localparam logic [19:0] VEC [16] = '{
    {4'd0, 16'd0},    {4'd1, 16'd128},  {4'd2, 16'd256},   {4'd3, 16'd4},
    {4'd4, 16'd8},    {4'd5, 16'd16},   {4'd6, 16'd32},    {4'd7, 16'd64},
    {4'd8, 16'd128},  {4'd9, 16'd256},  {4'd10, 16'd512},  {4'd11, 16'd1024},
    {4'd12, 16'd2048},{4'd13, 16'd4096},{4'd14, 16'd8192}, {4'd15, 16'd16384}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic [3:0] code);
    @(negedge clk);
    rst_n = 1'b0; div_ctl = 3'b010; rate_sel = code; osc_tick = 1'b1;
    sqw_en = 1'b1; force_32k = 1'b0; aux_en = 1'b0; aux_ok = 1'b0; main_low = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 190000);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int n, pulses, bad;
    bit got;
    logic prev;

    // R10: reset state
    rst_n = 1'b0; div_ctl = 3'b010; osc_tick = 1'b1; rate_sel = 4'd3; sqw_en = 1'b1;
    repeat (3) @(negedge clk);
    check(!sqw && !per_pulse && !sec_tick, "R10", {sqw, per_pulse, sec_tick}, 0);

    // R4/R1/R5/R6: table of rate codes
    for (int i = 0; i < 16; i++) begin
      int e;
      e = int'(VEC[i][15:0]);
      restart(VEC[i][19:16]);
      n = 0; got = 0;
      while (!got && n < ((e == 0) ? 2048 : e + 4)) begin
        @(negedge clk); n++;
        if (per_pulse) got = 1;
      end
      if (e == 0) begin
        check(!got, "R4", got, 0);
        check(!sqw, "R4", sqw, 0);
      end else begin
        check(n == e, "R4", n, e);
        check(sqw, "R6", sqw, 1);
        @(negedge clk);
        check(!per_pulse, "R5", per_pulse, 0);
      end
    end

    // R9: seconds tick latency
    restart(4'd0);
    n = 0; got = 0;
    while (!got && n < 33000) begin
      @(negedge clk); n++;
      if (sec_tick) got = 1;
    end
    check(n == 32768, "R9", n, 32768);
    @(negedge clk);
    check(!sec_tick, "R9", sec_tick, 0);

    // R6: sqw_en low masks pin but not pulses
    restart(4'd3);
    sqw_en = 1'b0; pulses = 0; bad = 0;
    repeat (64) begin @(negedge clk); pulses += int'(per_pulse); bad += int'(sqw); end
    check(bad == 0, "R6", bad, 0);
    check(pulses == 8, "R5", pulses, 8);

    // R7: force overrides rate code and enable
    restart(4'd5);
    sqw_en = 1'b0; force_32k = 1'b1; bad = 0;
    for (int k = 1; k <= 16; k++) begin @(negedge clk); if (sqw != k[0]) bad++; end
    check(bad == 0, "R7", bad, 0);

    // R2: hold clears chain, keeps phase running
    restart(4'd3);
    repeat (20) @(negedge clk);
    div_ctl = 3'b110; pulses = 0; bad = 0;
    repeat (64) begin @(negedge clk); pulses += int'(per_pulse) + int'(sec_tick); bad += int'(sqw); end
    check(pulses == 0, "R2", pulses, 0);
    check(bad == 0, "R2", bad, 0);
    force_32k = 1'b1; @(negedge clk); prev = sqw; bad = 0;
    repeat (8) begin @(negedge clk); if (sqw == prev) bad++; prev = sqw; end
    check(bad == 0, "R2", bad, 0);

    // R3: off freezes phase and chain
    div_ctl = 3'b000; @(negedge clk); prev = sqw; bad = 0;
    repeat (32) begin @(negedge clk); if (sqw != prev) bad++; end
    check(bad == 0, "R3", bad, 0);
    force_32k = 1'b0; div_ctl = 3'b100; pulses = 0;
    repeat (64) begin @(negedge clk); pulses += int'(per_pulse); end
    check(pulses == 0, "R3", pulses, 0);

    // R1: no tick, no advance
    restart(4'd3);
    osc_tick = 1'b0; pulses = 0;
    repeat (64) begin @(negedge clk); pulses += int'(per_pulse); end
    check(pulses == 0, "R1", pulses, 0);
    osc_tick = 1'b1; n = 0; got = 0;
    while (!got && n < 20) begin @(negedge clk); n++; if (per_pulse) got = 1; end
    check(n == 4, "R1", n, 4);

    // R8: supply low gating
    restart(4'd3);
    force_32k = 1'b1; main_low = 1'b1; bad = 0;
    repeat (16) begin @(negedge clk); bad += int'(sqw); end
    check(bad == 0, "R8", bad, 0);
    aux_en = 1'b1; aux_ok = 1'b1; @(negedge clk); prev = sqw; bad = 0;
    repeat (8) begin @(negedge clk); if (sqw == prev) bad++; prev = sqw; end
    check(bad == 0, "R8", bad, 0);
    aux_ok = 1'b0; bad = 0;
    repeat (16) begin @(negedge clk); bad += int'(sqw); end
    check(bad == 0, "R8", bad, 0);
    aux_ok = 1'b1; force_32k = 1'b0; bad = 0;
    repeat (16) begin @(negedge clk); bad += int'(sqw); end
    check(bad == 0, "R8", bad, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule